// File: doc/BRIEF.md
# PHY Interrupt Event Register Bank

This block is the management register bank of an Ethernet PHY, reduced to the parts that raise interrupts. It holds basic control, status and advertisement registers, plus a pair of registers that latch link events and mask them. A single-bit summary interrupt leaves the block and feeds the device-level interrupt status. Register accesses arrive on a simple strobe interface: a valid pulse, a write flag, a 5-bit register number and 16 bits of write data. Read data returns one cycle later with its own valid flag.

A link-up/link-down input drives event generation. Each transition of that input, and the first cycle after reset, updates the two link bits of the status register and latches a set of event bits. Software reads register 29 to learn which events occurred. That read also clears them, so the summary interrupt drops on the next cycle unless a new event arrives.

Top module: `phy_irq_regs`

## Requirements
- R1: After reset, register 0 reads 0x3000, register 4 reads 0x01E1 and register 30 reads 0. Register 1 reads 0x7809 when the link input is low. `rd_valid_o` and `phy_irq_o` are low while reset is held.
- R2: The link state present when reset is released is applied on the first clock. With the link low, register 29 then reads 0x0010.
- R3: A rise of the link input sets status bits 0x0024 in register 1. It also latches event bits 0x80 (energy detected) and 0x40 (negotiation done) in register 29.
- R4: A fall of the link input clears status bits 0x0024 in register 1 and latches event bit 0x10 (link lost) in register 29.
- R5: A read of register 29 returns the latched event bits in bits 7:0, with zeros above. The same read clears every latched bit.
- R6: A write to register 30 keeps only bits 7:0 of the write data as the mask. A read of register 30 returns that mask, zero-extended.
- R7: `phy_irq_o` is high exactly when the AND of the latched events and the mask is non-zero. It follows a mask write, an event or a clearing read on the next clock.
- R8: A write of V to register 4 stores (V AND 0x2D7F) OR 0x0080.
- R9: Register 6 always reads 0x0001, and writes to it have no effect.
- R10: Register numbers other than 0, 1, 4, 6, 29 and 30 read as 0, and writes to them are ignored. Register 1 is read-only.
- R11: An event latched in the same cycle as a clearing read of register 29 remains set after that read.
- R12: Every read strobe produces exactly one `rd_valid_o` pulse on the following cycle, carrying the data. Write strobes produce none.
- R13: A write to register 0 stores all 16 bits of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link state, high when the link is up, synchronous to clk |
| acc_valid_i | input | 1 | Register access strobe |
| acc_write_i | input | 1 | High for a write, low for a read |
| acc_reg_i | input | 5 | Register number |
| acc_wdata_i | input | 16 | Write data |
| rd_valid_o | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data_o | output | 16 | Read data |
| phy_irq_o | output | 1 | Summary interrupt |

## Verification
Two functions can land on the same clock edge: a link transition that latches new event bits, and a read of register 29 that clears the latch. The bench provokes this by changing the link input in the same cycle as it issues the clearing read. It then judges the result in two steps. The clearing read must return the old contents. A second read must return the freshly latched events, which shows they were not lost to the clear.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int DATA_W   = 16;
  localparam int IRQ_W    = 8;
  localparam int REGNUM_W = 5;

  localparam logic [REGNUM_W-1:0] REG_CTRL  = 5'd0;
  localparam logic [REGNUM_W-1:0] REG_STAT  = 5'd1;
  localparam logic [REGNUM_W-1:0] REG_ADV   = 5'd4;
  localparam logic [REGNUM_W-1:0] REG_ANEXP = 5'd6;
  localparam logic [REGNUM_W-1:0] REG_ISRC  = 5'd29;
  localparam logic [REGNUM_W-1:0] REG_IMASK = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_RST  = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_RST  = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_RST   = 16'h01E1;
  localparam logic [DATA_W-1:0] ADV_KEEP  = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCE = 16'h0080;
  localparam logic [DATA_W-1:0] STAT_LINK = 16'h0024;
  localparam logic [DATA_W-1:0] ANEXP_VAL = 16'h0001;

  localparam logic [IRQ_W-1:0] EV_ENERGY = 8'h80;
  localparam logic [IRQ_W-1:0] EV_ANDONE = 8'h40;
  localparam logic [IRQ_W-1:0] EV_LDOWN  = 8'h10;

  localparam int PAD_W = DATA_W - IRQ_W;
endpackage

// File: rtl/phy_link_event.sv
module phy_link_event
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_up_i,
  output logic             apply_o,
  output logic [IRQ_W-1:0] events_o
);
  logic link_q, link_d;
  logic init_q, init_d;
  logic upd_en;

  always_comb begin
    apply_o  = init_q | (link_up_i ^ link_q);
    upd_en   = apply_o;
    link_d   = link_up_i;
    init_d   = 1'b0;
    events_o = '0;
    if (apply_o) begin
      events_o = link_up_i ? (EV_ENERGY | EV_ANDONE) : EV_LDOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      init_q <= 1'b1;
    end else if (upd_en) begin
      link_q <= link_d;
      init_q <= init_d;
    end
  end

  AST_LINK_UP_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_o && link_up_i) |-> (events_o == (EV_ENERGY | EV_ANDONE))); // R3
  AST_LINK_DOWN_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_o && !link_up_i) |-> (events_o == EV_LDOWN)); // R4
  AST_NO_EVENT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_o ##1 $stable(link_up_i)) |-> !apply_o); // R2
endmodule

// File: rtl/phy_irq_latch.sv
module phy_irq_latch
  import phy_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] events_i,
  input  logic             rd_clr_i,
  input  logic             mask_we_i,
  input  logic [IRQ_W-1:0] mask_d_i,
  output logic [IRQ_W-1:0] src_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] src_q, src_d;
  logic [IRQ_W-1:0] mask_q;
  logic             src_en;

  always_comb begin
    src_en = rd_clr_i | (|events_i);
    src_d  = (rd_clr_i ? '0 : src_q) | events_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_d_i;
    end
  end

  assign src_o  = src_q;
  assign mask_o = mask_q;
  assign irq_o  = |(src_q & mask_q);

  AST_SRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (events_i == '0)) |=> (src_o == '0)); // R5
  AST_SRC_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (events_i != '0) |=> ((src_o & $past(events_i)) == $past(events_i))); // R11
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr_i && (events_i == '0)) |=> $stable(src_o)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_o == $past(mask_d_i))); // R6
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && (events_i == '0)) |=> !irq_o); // R7
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic [REGNUM_W-1:0] acc_reg_i,
  input  logic [DATA_W-1:0]   acc_wdata_i,
  input  logic                link_apply_i,
  input  logic                link_up_i,
  input  logic [IRQ_W-1:0]    src_i,
  input  logic [IRQ_W-1:0]    mask_i,
  output logic                rd_clr_o,
  output logic                mask_we_o,
  output logic                rd_valid_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] adv_q, adv_d;
  logic [DATA_W-1:0] rdat_q, rd_mux;
  logic              rval_q;
  logic              rd_stb, wr_stb;
  logic              ctrl_en, adv_en, stat_en;

  always_comb begin
    rd_stb    = acc_valid_i & ~acc_write_i;
    wr_stb    = acc_valid_i & acc_write_i;
    rd_clr_o  = rd_stb & (acc_reg_i == REG_ISRC);
    mask_we_o = wr_stb & (acc_reg_i == REG_IMASK);
    ctrl_en   = wr_stb & (acc_reg_i == REG_CTRL);
    adv_en    = wr_stb & (acc_reg_i == REG_ADV);
    stat_en   = link_apply_i;
    ctrl_d    = acc_wdata_i;
    adv_d     = (acc_wdata_i & ADV_KEEP) | ADV_FORCE;
    stat_d    = link_up_i ? (stat_q | STAT_LINK) : (stat_q & ~STAT_LINK);
  end

  always_comb begin
    case (acc_reg_i)
      REG_CTRL:  rd_mux = ctrl_q;
      REG_STAT:  rd_mux = stat_q;
      REG_ADV:   rd_mux = adv_q;
      REG_ANEXP: rd_mux = ANEXP_VAL;
      REG_ISRC:  rd_mux = {{PAD_W{1'b0}}, src_i};
      REG_IMASK: rd_mux = {{PAD_W{1'b0}}, mask_i};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q <= ADV_RST;
    end else if (adv_en) begin
      adv_q <= adv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rval_q <= 1'b0;
    end else begin
      rval_q <= rd_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
    end else if (rd_stb) begin
      rdat_q <= rd_mux;
    end
  end

  assign rd_valid_o = rval_q;
  assign rd_data_o  = rdat_q;

  AST_ADV_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (acc_reg_i == REG_ADV)) |=>
      ((adv_q & ~ADV_KEEP) == ADV_FORCE)); // R8
  AST_STAT_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (link_apply_i && link_up_i) |=> ((stat_q & STAT_LINK) == STAT_LINK)); // R3
  AST_STAT_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (link_apply_i && !link_up_i) |=> ((stat_q & STAT_LINK) == '0)); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid_o); // R12
  AST_NO_STRAY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid_o); // R12
  AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    !link_apply_i |=> $stable(stat_q)); // R10
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_up_i,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic [REGNUM_W-1:0] acc_reg_i,
  input  logic [DATA_W-1:0]   acc_wdata_i,
  output logic                rd_valid_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                phy_irq_o
);
  logic             link_apply;
  logic [IRQ_W-1:0] link_events;
  logic [IRQ_W-1:0] src_bits;
  logic [IRQ_W-1:0] mask_bits;
  logic             rd_clr;
  logic             mask_we;

  phy_link_event u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up_i (link_up_i),
    .apply_o   (link_apply),
    .events_o  (link_events)
  );

  phy_irq_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .events_i  (link_events),
    .rd_clr_i  (rd_clr),
    .mask_we_i (mask_we),
    .mask_d_i  (acc_wdata_i[IRQ_W-1:0]),
    .src_o     (src_bits),
    .mask_o    (mask_bits),
    .irq_o     (phy_irq_o)
  );

  phy_reg_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .acc_reg_i    (acc_reg_i),
    .acc_wdata_i  (acc_wdata_i),
    .link_apply_i (link_apply),
    .link_up_i    (link_up_i),
    .src_i        (src_bits),
    .mask_i       (mask_bits),
    .rd_clr_o     (rd_clr),
    .mask_we_o    (mask_we),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );

  AST_IRQ_AFTER_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_write_i && (acc_reg_i == REG_IMASK) &&
     (acc_wdata_i[IRQ_W-1:0] == '0)) |=> !phy_irq_o); // R7
endmodule

// File: tb/phy_irq_regs_test.sv
module phy_irq_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [4:0]  acc_reg_i = '0;
  logic [15:0] acc_wdata_i = '0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic        phy_irq_o;

  int total = 0;
  int bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_regs uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_up_i   (link_up_i),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .acc_reg_i   (acc_reg_i),
    .acc_wdata_i (acc_wdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .phy_irq_o   (phy_irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every read return (R12)
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected read return", rd_data_o, 16'h0000);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rd_data_o == e, t, rd_data_o, e);
      end
    end
  end

  task automatic do_read(input logic [4:0] r, input logic [15:0] e, input string t);
    @(posedge clk); #1;
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_reg_i = r;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    acc_valid_i = 1'b0;
  endtask

  task automatic do_write(input logic [4:0] r, input logic [15:0] d);
    @(posedge clk); #1;
    acc_valid_i = 1'b1; acc_write_i = 1'b1; acc_reg_i = r; acc_wdata_i = d;
    @(posedge clk); #1;
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic set_link(input logic v);
    @(posedge clk); #1;
    link_up_i = v;
    @(posedge clk); #1;
  endtask

  task automatic check_irq(input logic e, input string t);
    check(phy_irq_o == e, t, {15'd0, phy_irq_o}, {15'd0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog expired", 16'h0, 16'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(rd_valid_o == 1'b0, "R1 rd_valid in reset", {15'd0, rd_valid_o}, 16'h0);
    check_irq(1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset values
    do_read(5'd0, 16'h3000, "R1 control reset");
    do_read(5'd1, 16'h7809, "R1 status reset, link low");
    do_read(5'd4, 16'h01E1, "R1 advertise reset");
    do_read(5'd30, 16'h0000, "R1 mask reset");
    check_irq(1'b0, "R7 irq low with zero mask");

    // R2 initial link application, R5 clear on read
    do_read(5'd29, 16'h0010, "R2 link-down event after reset");
    do_read(5'd29, 16'h0000, "R5 source cleared by read");

    // R6 mask keeps low byte
    do_write(5'd30, 16'hFF90);
    do_read(5'd30, 16'h0090, "R6 mask low byte only");
    check_irq(1'b0, "R7 irq low with empty source");

    // R3 link up
    set_link(1'b1);
    check_irq(1'b1, "R7 irq high on masked event");
    do_read(5'd1, 16'h782D, "R3 status link bits set");
    do_read(5'd29, 16'h00C0, "R3 link-up events");
    check_irq(1'b0, "R7 irq drops after clearing read");

    // R4 link down
    do_write(5'd30, 16'h0040);
    set_link(1'b0);
    check_irq(1'b0, "R7 irq low, event not in mask");
    do_read(5'd1, 16'h7809, "R4 status link bits cleared");
    do_write(5'd30, 16'h0010);
    check_irq(1'b1, "R7 irq follows mask write");
    do_read(5'd29, 16'h0010, "R4 link-down event");
    check_irq(1'b0, "R7 irq low after read");

    // R8 advertisement format
    do_write(5'd4, 16'hFFFF);
    do_read(5'd4, 16'h2DFF, "R8 advertise all ones");
    do_write(5'd4, 16'h0000);
    do_read(5'd4, 16'h0080, "R8 advertise forced bit");

    // R9 expansion register constant
    do_read(5'd6, 16'h0001, "R9 expansion reads one");
    do_write(5'd6, 16'hFFFF);
    do_read(5'd6, 16'h0001, "R9 expansion write ignored");

    // R10 unimplemented and read-only
    do_write(5'd12, 16'hABCD);
    do_read(5'd12, 16'h0000, "R10 unimplemented reads zero");
    do_write(5'd1, 16'h0000);
    do_read(5'd1, 16'h7809, "R10 status write ignored");

    // R13 control full write
    do_write(5'd0, 16'h1234);
    do_read(5'd0, 16'h1234, "R13 control stores word");

    // R11 event and clearing read in the same cycle
    @(posedge clk); #1;
    link_up_i = 1'b1;
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_reg_i = 5'd29;
    exp_q.push_back(16'h0000); tag_q.push_back("R11 clearing read returns old source");
    @(posedge clk); #1;
    acc_valid_i = 1'b0;
    do_read(5'd29, 16'h00C0, "R11 same-cycle event survives read");

    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R12 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule